// File: doc/BRIEF.md
# T1/E1 Framing Overhead Inserter

This block sits in a transmit path that carries one line bit per enabled clock cycle. It counts bit and frame position inside the current multiframe by itself. At the overhead positions of the selected line format, it replaces the incoming bit with the framing pattern value that belongs at that position. All other bits pass straight through. The output is registered, so every bit appears exactly one enabled cycle after it enters.

Five line formats are handled:

- Three 12-frame T1 formats:
  - superframe (code 0)
  - SLC-96 (code 1)
  - T1DM (code 2)
- The 24-frame T1 extended superframe (code 3).
- The E1 16-frame multiframe (code 4).

Codes 5 to 7 are reserved. Under a reserved code nothing is overwritten, and positions are counted as in a 12-frame T1 superframe.

Two enables control insertion:

- `fbit_ins` covers the basic frame-alignment bits.
- `mfa_ins` covers the multiframe-alignment bits.

Both enables act on the bit they arrive with. A change of `line_fmt` is held back until the current multiframe ends.

A small two-state machine in the position tracker follows where the current bit lies in the frame:

- `SLOT_OVH` is the overhead region: bit 0 of a T1 frame, or bits 0..7 of an E1 frame.
- `SLOT_PAY` is the payload.

The transitions are:

- OVH_DONE: `SLOT_OVH` to `SLOT_PAY`, on the enabled last overhead bit.
- FRAME_END: `SLOT_PAY` to `SLOT_OVH`, on the enabled last bit of the frame.
- Reset forces `SLOT_OVH`.

Top module: `t1e1_oh_inserter`

## Requirements
- R1: A synchronous reset (`rst_n` low at a clock edge) sets `dout` to 0. It places the position at bit 0 of frame 0 of a multiframe and adopts `line_fmt` at once as the active format. Frames and bits are numbered from 0.
- R2: When `bit_en` is high, the bit on `din` appears on `dout` after that edge, unless it is overwritten. When `bit_en` is low, `dout` and the position hold. A T1 frame is 193 bits and an E1 frame 256 bits. The multiframe is 12 frames for codes 0, 1, 2, 5, 6 and 7, 24 frames for code 3, and 16 frames for code 4.
- R3: In codes 0, 1 and 2 with `fbit_ins` set, bit 0 of frames 0,2,4,6,8,10 carries 1,0,1,0,1,0 in that frame order.
- R4: In codes 0 and 1 with `mfa_ins` set, bit 0 of frames 1,3,5,7,9,11 carries 0,0,1,1,1,0. In code 2, bit 0 of odd frames is never overwritten.
- R5: In code 3 with `fbit_ins` set, bit 0 of frames 3,7,11,15,19,23 carries 0,0,1,0,1,1. The other frame bits pass through.
- R6: In code 4 with `fbit_ins` set, bits 1..7 of every even frame carry 0,0,1,1,0,1,1. Bit 0 of even frames passes through.
- R7: In code 4 with `fbit_ins` set, bit 1 of every odd frame is 1.
- R8: In code 4 with `mfa_ins` set, bit 0 of frames 1,3,5,7,9,11 carries 0,0,1,0,1,1. Bit 0 of frames 13 and 15 passes through.
- R9: An overhead position whose enable is clear passes `din` through unchanged.
- R10: A new `line_fmt` value takes effect only when the current multiframe wraps to frame 0, bit 0. Until then, lengths and patterns follow the previous format.
- R11: Under codes 5, 6 and 7 no bit is overwritten.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | One line bit is transferred in this cycle |
| din | input | 1 | Incoming transmit bit |
| line_fmt | input | 3 | Requested line format code |
| fbit_ins | input | 1 | Enable for frame-alignment bit insertion |
| mfa_ins | input | 1 | Enable for multiframe-alignment bit insertion |
| dout | output | 1 | Outgoing transmit bit, one enabled cycle late |

## Verification
The in-line assertions assume that reset is applied in the first cycles. They assume that `bit_en`, `din` and both insert enables are stable around each rising edge, and that `line_fmt` may change at any cycle. The bench drives every input only on falling edges and starts with reset held. It requests each format mid-multiframe, so the deferred switch is always crossed. It withholds `bit_en` at a fixed stride to cover the hold behaviour. It also applies one reset in the middle of an E1 multiframe to check that counting restarts at frame 0.

// File: rtl/t1e1_oh_pkg.sv
package t1e1_oh_pkg;

    typedef enum logic [2:0] {
        FMT_SF   = 3'd0,
        FMT_SLC  = 3'd1,
        FMT_T1DM = 3'd2,
        FMT_ESF  = 3'd3,
        FMT_E1   = 3'd4
    } line_fmt_e;

    typedef enum logic [0:0] {
        SLOT_OVH = 1'b0,
        SLOT_PAY = 1'b1
    } slot_e;

    // Pattern words, read MSB first as the sequence index goes up.
    localparam logic [5:0] FT_WORD   = 6'b101010;
    localparam logic [5:0] FS_WORD   = 6'b001110;
    localparam logic [5:0] FPS_WORD  = 6'b001011;
    localparam logic [5:0] E1MF_WORD = 6'b001011;
    // Index 6..0 map to bit positions 1..7 of timeslot 0; bit 7 is unused.
    localparam logic [7:0] FAS_WORD  = 8'b0001_1011;

    function automatic logic is_t1_sf_family(logic [2:0] f);
        return (f == FMT_SF) || (f == FMT_SLC) || (f == FMT_T1DM);
    endfunction

endpackage

// File: rtl/t1e1_oh_position.sv
module t1e1_oh_position
    import t1e1_oh_pkg::*;
#(
    parameter int T1_BITS     = 193,
    parameter int E1_BITS     = 256,
    parameter int E1_OVH_BITS = 8,
    parameter int SF_FRAMES   = 12,
    parameter int ESF_FRAMES  = 24,
    parameter int E1_FRAMES   = 16,
    localparam int BW = $clog2((T1_BITS > E1_BITS) ? T1_BITS : E1_BITS),
    localparam int FW = $clog2(ESF_FRAMES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    input  logic [2:0]    fmt_req,
    output logic [2:0]    act_fmt,
    output logic [FW-1:0] frm_idx,
    output logic [BW-1:0] bit_idx,
    output slot_e         slot
);

    localparam logic [BW-1:0] T1_LAST    = BW'(T1_BITS - 1);
    localparam logic [BW-1:0] E1_LAST    = BW'(E1_BITS - 1);
    localparam logic [BW-1:0] E1_OVH_END = BW'(E1_OVH_BITS - 1);
    localparam logic [FW-1:0] SF_LAST    = FW'(SF_FRAMES - 1);
    localparam logic [FW-1:0] ESF_LAST   = FW'(ESF_FRAMES - 1);
    localparam logic [FW-1:0] E1F_LAST   = FW'(E1_FRAMES - 1);

    slot_e         slot_d;
    logic [BW-1:0] bit_last;
    logic [BW-1:0] ovh_end;
    logic [FW-1:0] frm_last;
    logic          at_bit_end;
    logic          at_mf_end;

    always_comb begin
        if (act_fmt == FMT_E1) begin
            bit_last = E1_LAST;
            ovh_end  = E1_OVH_END;
            frm_last = E1F_LAST;
        end else if (act_fmt == FMT_ESF) begin
            bit_last = T1_LAST;
            ovh_end  = '0;
            frm_last = ESF_LAST;
        end else begin
            bit_last = T1_LAST;
            ovh_end  = '0;
            frm_last = SF_LAST;
        end
        at_bit_end = (bit_idx == bit_last);
        at_mf_end  = at_bit_end && (frm_idx == frm_last);
    end

    // Position counters and format latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_idx <= '0;
            frm_idx <= '0;
            act_fmt <= fmt_req;
        end else if (bit_en) begin
            if (at_bit_end) begin
                bit_idx <= '0;
                if (at_mf_end) begin
                    frm_idx <= '0;
                    act_fmt <= fmt_req;
                end else begin
                    frm_idx <= frm_idx + FW'(1);
                end
            end else begin
                bit_idx <= bit_idx + BW'(1);
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) slot <= SLOT_OVH;
        else        slot <= slot_d;
    end

    // Next-state logic
    always_comb begin
        slot_d = slot;
        unique case (slot)
            SLOT_OVH: if (bit_en && (bit_idx == ovh_end))  slot_d = SLOT_PAY;
            SLOT_PAY: if (bit_en && at_bit_end)            slot_d = SLOT_OVH;
        endcase
    end

    assert_bit_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_idx <= bit_last);

    assert_hold_position_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(bit_idx) && $stable(frm_idx)));

    assert_fmt_only_at_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_en && at_mf_end) |=> $stable(act_fmt));

    assert_slot_in_overhead_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_OVH) |-> (bit_idx <= ovh_end));

endmodule

// File: rtl/t1e1_oh_pattern.sv
module t1e1_oh_pattern
    import t1e1_oh_pkg::*;
#(
    parameter int BW = 8,
    parameter int FW = 5
) (
    input  logic [2:0]    act_fmt,
    input  logic [FW-1:0] frm_idx,
    input  logic [BW-1:0] bit_idx,
    input  slot_e         slot,
    input  logic          fbit_ins,
    input  logic          mfa_ins,
    output logic          ovr,
    output logic          ovr_val
);

    logic [2:0] k_half;
    logic [2:0] k_quarter;
    logic [2:0] seq_half;
    logic [2:0] seq_quarter;
    logic [2:0] fas_sel;
    logic       bit0;
    logic       bit1;
    logic       frm_odd;

    always_comb begin
        k_half      = 3'(frm_idx >> 1);
        k_quarter   = 3'(frm_idx >> 2);
        seq_half    = 3'd5 - k_half;
        seq_quarter = 3'd5 - k_quarter;
        fas_sel     = 3'd7 - bit_idx[2:0];
        bit0        = (bit_idx == '0);
        bit1        = (bit_idx == BW'(1));
        frm_odd     = frm_idx[0];
        ovr         = 1'b0;
        ovr_val     = 1'b0;
        if (slot == SLOT_OVH) begin
            case (act_fmt)
                FMT_SF, FMT_SLC: begin
                    if (bit0 && !frm_odd && fbit_ins) begin
                        ovr = 1'b1; ovr_val = FT_WORD[seq_half];
                    end else if (bit0 && frm_odd && mfa_ins) begin
                        ovr = 1'b1; ovr_val = FS_WORD[seq_half];
                    end
                end
                FMT_T1DM: begin
                    if (bit0 && !frm_odd && fbit_ins) begin
                        ovr = 1'b1; ovr_val = FT_WORD[seq_half];
                    end
                end
                FMT_ESF: begin
                    if (bit0 && (frm_idx[1:0] == 2'b11) && fbit_ins) begin
                        ovr = 1'b1; ovr_val = FPS_WORD[seq_quarter];
                    end
                end
                FMT_E1: begin
                    if (!frm_odd) begin
                        if (!bit0 && fbit_ins) begin
                            ovr = 1'b1; ovr_val = FAS_WORD[fas_sel];
                        end
                    end else begin
                        if (bit1 && fbit_ins) begin
                            ovr = 1'b1; ovr_val = 1'b1;
                        end else if (bit0 && mfa_ins && (frm_idx < FW'(12))) begin
                            ovr = 1'b1; ovr_val = E1MF_WORD[seq_half];
                        end
                    end
                end
                default: begin
                    ovr     = 1'b0;
                    ovr_val = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/t1e1_oh_inserter.sv
module t1e1_oh_inserter
    import t1e1_oh_pkg::*;
#(
    parameter int T1_BITS     = 193,
    parameter int E1_BITS     = 256,
    parameter int E1_OVH_BITS = 8,
    parameter int SF_FRAMES   = 12,
    parameter int ESF_FRAMES  = 24,
    parameter int E1_FRAMES   = 16,
    localparam int BW = $clog2((T1_BITS > E1_BITS) ? T1_BITS : E1_BITS),
    localparam int FW = $clog2(ESF_FRAMES)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       din,
    input  logic [2:0] line_fmt,
    input  logic       fbit_ins,
    input  logic       mfa_ins,
    output logic       dout
);

    logic [2:0]    act_fmt;
    logic [FW-1:0] frm_idx;
    logic [BW-1:0] bit_idx;
    slot_e         slot;
    logic          ovr;
    logic          ovr_val;

    t1e1_oh_position #(
        .T1_BITS(T1_BITS), .E1_BITS(E1_BITS), .E1_OVH_BITS(E1_OVH_BITS),
        .SF_FRAMES(SF_FRAMES), .ESF_FRAMES(ESF_FRAMES), .E1_FRAMES(E1_FRAMES)
    ) u_pos (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fmt_req(line_fmt),
        .act_fmt(act_fmt), .frm_idx(frm_idx), .bit_idx(bit_idx), .slot(slot)
    );

    t1e1_oh_pattern #(.BW(BW), .FW(FW)) u_pat (
        .act_fmt(act_fmt), .frm_idx(frm_idx), .bit_idx(bit_idx), .slot(slot),
        .fbit_ins(fbit_ins), .mfa_ins(mfa_ins), .ovr(ovr), .ovr_val(ovr_val)
    );

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n)      dout <= 1'b0;
        else if (bit_en) dout <= ovr ? ovr_val : din;
    end

    assert_dout_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(dout));

    assert_passthru_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !fbit_ins && !mfa_ins) |=> (dout == $past(din)));

    assert_ft_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && fbit_ins && is_t1_sf_family(act_fmt) && (bit_idx == '0) && !frm_idx[0])
        |=> (dout == !$past(frm_idx[1])));

    assert_nfas_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && fbit_ins && (act_fmt == FMT_E1) && frm_idx[0] && (bit_idx == BW'(1)))
        |=> dout);

    assert_reserved_passthru_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && (act_fmt > FMT_E1)) |=> (dout == $past(din)));

endmodule

// File: tb/sim_t1e1_oh_inserter.sv
module sim_t1e1_oh_inserter;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       din = 1'b0;
    logic [2:0] line_fmt = 3'd0;
    logic       fbit_ins = 1'b0;
    logic       mfa_ins = 1'b0;
    logic       dout;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [15:0] lfsr = 16'hACE1;

    // Bench-side model of position
    int m_fmt = 0;
    int m_f = 0;
    int m_b = 0;
    logic m_exp = 1'b0;

    t1e1_oh_inserter u0 (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .din(din),
        .line_fmt(line_fmt), .fbit_ins(fbit_ins), .mfa_ins(mfa_ins), .dout(dout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int frame_len(int fm);
        return (fm == 4) ? 256 : 193;
    endfunction

    function automatic int mf_len(int fm);
        return (fm == 4) ? 16 : ((fm == 3) ? 24 : 12);
    endfunction

    // Expected output bit and the requirement it exercises
    function automatic logic model_bit(int fm, int f, int b, logic fi, logic mi,
                                       logic d, output string rq);
        int k2 = f / 2;
        int k4 = f / 4;
        rq = "R2";
        if (fm <= 2 && b == 0) begin
            if (f % 2 == 0) begin
                rq = fi ? "R3" : "R9";
                if (fi) return (k2 % 2 == 0);
            end else begin
                rq = "R4";
                if (fm != 2 && mi) return (k2 >= 2 && k2 <= 4);
                if (fm != 2) rq = "R9";
            end
        end else if (fm == 3 && b == 0) begin
            if (f % 4 == 3) begin
                rq = fi ? "R5" : "R9";
                if (fi) return (k4 == 2 || k4 >= 4);
            end else rq = "R5";
        end else if (fm == 4) begin
            if (f % 2 == 0) begin
                if (b >= 1 && b <= 7) begin
                    rq = fi ? "R6" : "R9";
                    if (fi) return (b == 3 || b == 4 || b >= 6);
                end else if (b == 0) rq = "R6";
            end else begin
                if (b == 1) begin
                    rq = fi ? "R7" : "R9";
                    if (fi) return 1'b1;
                end else if (b == 0) begin
                    rq = (mi || f > 11) ? "R8" : "R9";
                    if (mi && f <= 11) return (k2 == 2 || k2 >= 4);
                end
            end
        end else if (fm >= 5) begin
            rq = "R11";
        end
        return d;
    endfunction

    task automatic check(logic act, logic exp, string rq);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: cycle %0d fmt %0d frame %0d bit %0d dout=%b expected=%b",
                     rq, cyc, m_fmt, m_f, m_b, act, exp);
        end
    endtask

    // Apply reset, then check the reset state (R1)
    task automatic do_reset(int cycles);
        @(negedge clk);
        rst_n = 1'b0;
        bit_en = 1'b0;
        repeat (cycles) @(negedge clk);
        m_fmt = int'(line_fmt);
        m_f = 0;
        m_b = 0;
        m_exp = 1'b0;
        check(dout, 1'b0, "R1");
        rst_n = 1'b1;
    endtask

    // Run n enabled bits; caller is at a negedge
    task automatic run_bits(int n);
        string rq;
        string tag;
        int done = 0;
        while (done < n) begin
            logic en;
            en = ((cyc % 7) != 3);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            din = lfsr[0];
            bit_en = en;
            tag = "R2";
            if (en) begin
                m_exp = model_bit(m_fmt, m_f, m_b, fbit_ins, mfa_ins, din, rq);
                tag = (m_fmt != int'(line_fmt)) ? {rq, "/R10"} : rq;
                if (m_b == frame_len(m_fmt) - 1) begin
                    m_b = 0;
                    if (m_f == mf_len(m_fmt) - 1) begin
                        m_f = 0;
                        m_fmt = int'(line_fmt);
                    end else m_f++;
                end else m_b++;
                done++;
            end
            @(posedge clk);
            @(negedge clk);
            cyc++;
            check(dout, m_exp, tag);
        end
    endtask

    initial begin
        do_reset(3);
        for (int fm = 0; fm < 8; fm++) begin
            if (fm == 6) continue;
            for (int ins = 0; ins < 4; ins++) begin
                line_fmt = 3'(fm);
                fbit_ins = ins[0];
                mfa_ins  = ins[1];
                run_bits(frame_len(fm) * mf_len(fm) + 300);
            end
        end
        // Reset in the middle of an E1 multiframe: counting restarts (R1)
        line_fmt = 3'd4;
        fbit_ins = 1'b1;
        mfa_ins  = 1'b1;
        run_bits(5000);
        do_reset(2);
        run_bits(1200);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule